// File: doc/BRIEF.md
# Row/Column Multiplexed Memory Read Controller

This block connects a processor-side request port to a dynamic memory device whose row and column addresses share a single set of address pins. When a request is raised, the block captures a full word address, a read/write flag and a write word. The upper address bits form the row and the lower bits form the column. The block then runs a fixed sequence on the device pins. First it presents the row under an active-low row strobe. It waits a programmable row-activation time. It then presents the column under an active-low column strobe, with chip-select and an active-low write-enable driven throughout the access.

A read returns four words from the open row in four consecutive cycles. The first word arrives one cycle after the column strobe. The column then steps by one on each beat and wraps inside the column field. While the words stream, the block shows the current column on the address pins and marks each word with a valid flag. A write moves one word, which is placed on the device data output in the column-strobe cycle. A busy flag covers the whole access, and new requests are not taken while it is high.

Top module: `rowcol_mem_ctrl`

## Requirements
- R1: While reset is asserted, and whenever busy_o is low, mem_cs_no, mem_ras_no, mem_cas_no and mem_we_no are all 1, and rvalid_o is 0.
- R2: In the cycle after a request is accepted, mem_cs_no=0, mem_ras_no=0 and mem_cas_no=1. mem_addr_o carries addr_i[ROW_W+COL_W-1:COL_W], zero-extended to MA_W.
- R3: mem_cas_no goes to 0 exactly ACT_CYC cycles after the row-strobe cycle, where ACT_CYC is 2 or 3. In the cycles in between, mem_cs_no=0 and both strobes are 1.
- R4: In the column-strobe cycle, mem_addr_o carries addr_i[COL_W-1:0], zero-extended. mem_we_no is 0 when we_i was 1 at acceptance, and 1 otherwise.
- R5: For a read, rvalid_o rises in the cycle after the column strobe. rdata_o equals mem_dq_i in every cycle where rvalid_o is 1.
- R6: A read delivers exactly four words in four consecutive cycles. These are the words of the selected row at columns c, c+1, c+2 and c+3.
- R7: During the burst, mem_addr_o shows the current column. It starts at c and steps by one per beat, modulo 2^COL_W, so 7 is followed by 0 when COL_W=3.
- R8: A write moves one word. mem_dq_o equals the wdata_i captured at acceptance in the column-strobe cycle. rvalid_o never rises, and busy_o is low in the next cycle.
- R9: busy_o is 1 from the cycle after acceptance through the last burst beat (read) or the column-strobe cycle (write), and 0 otherwise. A request is accepted only on a clock edge where busy_o is 0.
- R10: A request raised while busy_o is 1 is ignored. It produces no further row strobe and does not change the address, data or direction of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ROW_W+COL_W | Word address (row high, column low) |
| wdata_i | input | DATA_W | Write word |
| busy_o | output | 1 | Access in progress |
| rvalid_o | output | 1 | Read word valid |
| rdata_o | output | DATA_W | Read word |
| mem_addr_o | output | MA_W | Shared row/column address pins |
| mem_ras_no | output | 1 | Row strobe, active low |
| mem_cas_no | output | 1 | Column strobe, active low |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Write data to device |
| mem_dq_i | input | DATA_W | Read data from device |

## Verification
The bench uses ROW_W=5, COL_W=3, DATA_W=16 and ACT_CYC=3. The three-cycle activation setting exercises the path where the timer runs for more than one waiting cycle. A column field of only eight entries lets reads that start at columns 6 and 7 cross the wrap point. Because the row is wider than the column, the zero-padding of the column on the shared pins is also observed. A small device model with a 256-word array makes it possible to write a word and then read it back from inside a burst.

// File: rtl/rowcol_pkg.sv
package rowcol_pkg;
  localparam int unsigned BURST_LEN = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_ACT,
    ST_COL,
    ST_BURST
  } rc_state_e;
endpackage

// File: rtl/rc_addr_split.sv
module rc_addr_split #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 4,
  parameter int unsigned MA_W  = 6
) (
  input  logic [ROW_W+COL_W-1:0] addr_i,
  output logic [MA_W-1:0]        row_pins_o,
  output logic [MA_W-1:0]        col_pins_o
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  assign row = addr_i[ROW_W+COL_W-1:COL_W];
  assign col = addr_i[COL_W-1:0];

  if (MA_W > ROW_W) begin : g_row_pad
    assign row_pins_o = {{(MA_W-ROW_W){1'b0}}, row};
  end else begin : g_row_full
    assign row_pins_o = row;
  end

  if (MA_W > COL_W) begin : g_col_pad
    assign col_pins_o = {{(MA_W-COL_W){1'b0}}, col};
  end else begin : g_col_full
    assign col_pins_o = col;
  end
endmodule

// File: rtl/rc_delay_timer.sv
module rc_delay_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/rc_burst_track.sv
module rc_burst_track #(
  parameter int unsigned COL_W     = 4,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BEAT_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [COL_W-1:0]  col_q;
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      beat_q <= '0;
    end else if (start_i) begin
      col_q  <= col_i;
      beat_q <= '0;
    end else if (step_i) begin
      col_q  <= col_q + 1'b1;  // wraps inside the column field
      beat_q <= beat_q + 1'b1;
    end
  end

  assign col_o  = col_q;
  assign last_o = (beat_q == BEAT_W'(BURST_LEN - 1));
endmodule

// File: rtl/rowcol_mem_ctrl.sv
module rowcol_mem_ctrl
  import rowcol_pkg::*;
#(
  parameter int unsigned ROW_W   = 6,
  parameter int unsigned COL_W   = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ACT_CYC = 2,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic              mem_ras_no,
  output logic              mem_cas_no,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned TMR_W = $clog2(ACT_CYC + 1);

  rc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              accept;
  logic [MA_W-1:0]   row_pins, col_pins;
  logic              act_last;
  logic [COL_W-1:0]  burst_col;
  logic              burst_last;

  assign accept = (state_q == ST_IDLE) && req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      we_q    <= we_i;
    end
  end

  rc_addr_split #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .MA_W  (MA_W)
  ) u_split (
    .addr_i     (addr_q),
    .row_pins_o (row_pins),
    .col_pins_o (col_pins)
  );

  // loaded as the row strobe goes out; ACT_CYC-1 waiting cycles follow
  rc_delay_timer #(
    .CNT_W (TMR_W)
  ) u_act_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (state_q == ST_ROW),
    .load_val_i (TMR_W'(ACT_CYC - 1)),
    .last_o     (act_last)
  );

  rc_burst_track #(
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN)
  ) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(state_q == ST_COL),
    .step_i (state_q == ST_BURST),
    .col_i  (addr_q[COL_W-1:0]),
    .col_o  (burst_col),
    .last_o (burst_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_ROW;
      ST_ROW:   state_d = ST_ACT;
      ST_ACT:   if (act_last) state_d = ST_COL;
      ST_COL:   state_d = we_q ? ST_IDLE : ST_BURST;
      ST_BURST: if (burst_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_ROW:   mem_addr_o = row_pins;
      ST_COL:   mem_addr_o = col_pins;
      ST_BURST: mem_addr_o = MA_W'(burst_col);
      default:  mem_addr_o = '0;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign mem_cs_no  = ~busy_o;
  assign mem_ras_no = (state_q != ST_ROW);
  assign mem_cas_no = (state_q != ST_COL);
  assign mem_we_no  = ~((state_q == ST_COL) && we_q);
  assign mem_dq_o   = ((state_q == ST_COL) && we_q) ? wdata_q : '0;
  assign rvalid_o   = (state_q == ST_BURST);
  assign rdata_o    = rvalid_o ? mem_dq_i : '0;
endmodule

// File: rtl/rowcol_mem_ctrl_chk.sv
module rowcol_mem_ctrl_chk #(
  parameter int unsigned ACT_CYC = 2,
  parameter int unsigned COL_W   = 4,
  parameter int unsigned MA_W    = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            busy_o,
  input logic            rvalid_o,
  input logic [MA_W-1:0] mem_addr_o,
  input logic            mem_ras_no,
  input logic            mem_cas_no,
  input logic            mem_cs_no,
  input logic            mem_we_no
);
  logic [2:0]       since_ras_q;
  logic [2:0]       run_q;
  logic [COL_W-1:0] col_now;

  assign col_now = mem_addr_o[COL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                since_ras_q <= '0;
    else if (!mem_ras_no)                       since_ras_q <= 3'd1;
    else if (!mem_cas_no)                       since_ras_q <= '0;
    else if (since_ras_q != '0 && since_ras_q != 3'd7) since_ras_q <= since_ras_q + 3'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (rvalid_o) run_q <= run_q + 3'd1;
    else               run_q <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_cs_no && mem_ras_no && mem_cas_no && mem_we_no && !rvalid_o));

  p_strobe_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ras_no || !mem_cas_no) |-> (!mem_cs_no && (mem_ras_no || mem_cas_no)));

  p_act_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cas_no |-> (since_ras_q == 3'(ACT_CYC)));

  p_first_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> ($past(!mem_cas_no) && $past(mem_we_no) && mem_addr_o == $past(mem_addr_o)));

  p_burst_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rvalid_o) |-> (run_q == 3'd4));

  p_col_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(rvalid_o)) |-> (col_now == $past(col_now) + 1'b1));

  p_write_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cas_no && !mem_we_no) |=> (!rvalid_o && !busy_o));

  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> (busy_o && !mem_ras_no));

  p_no_rerow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || mem_ras_no));
endmodule

bind rowcol_mem_ctrl rowcol_mem_ctrl_chk #(
  .ACT_CYC (ACT_CYC),
  .COL_W   (COL_W),
  .MA_W    (MA_W)
) u_chk (.*);

// File: tb/rowcol_mem_ctrl_tb.sv
module rowcol_mem_ctrl_tb;
  localparam int ROW_W = 5;
  localparam int COL_W = 3;
  localparam int DW    = 16;
  localparam int ACT   = 3;
  localparam int AW    = ROW_W + COL_W;
  localparam int MA_W  = 5;
  localparam int NV    = 10;

  // {we, addr[7:0], wdata[15:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h1A, 16'hBEEF},
    {1'b0, 8'h18, 16'h0000},
    {1'b1, 8'h1F, 16'h1234},
    {1'b0, 8'h1E, 16'h0000},
    {1'b0, 8'hFF, 16'h0000},
    {1'b1, 8'h00, 16'hA5A5},
    {1'b0, 8'h00, 16'h0000},
    {1'b1, 8'hE5, 16'h0F0F},
    {1'b0, 8'hE3, 16'h0000},
    {1'b0, 8'h55, 16'h0000}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          busy_o, rvalid_o;
  logic [DW-1:0] rdata_o, mem_dq_o, mem_dq_i;
  logic [MA_W-1:0] mem_addr_o;
  logic          mem_ras_no, mem_cas_no, mem_cs_no, mem_we_no;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] dev_mem [256];
  logic [DW-1:0] exp_mem [256];
  logic [ROW_W-1:0] dev_row;
  logic [COL_W-1:0] dev_col;
  int               dev_left = 0;

  always #4 clk_i = ~clk_i;

  rowcol_mem_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .ACT_CYC(ACT)
  ) u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .busy_o, .rvalid_o, .rdata_o, .mem_addr_o,
    .mem_ras_no, .mem_cas_no, .mem_cs_no, .mem_we_no,
    .mem_dq_o, .mem_dq_i
  );

  // device model: row latched by row strobe, column by column strobe,
  // read words on the four cycles after the column strobe
  always @(posedge clk_i) begin
    if (!mem_cs_no && !mem_ras_no) dev_row <= mem_addr_o[ROW_W-1:0];
    if (!mem_cs_no && !mem_cas_no) begin
      if (!mem_we_no) dev_mem[{dev_row, mem_addr_o[COL_W-1:0]}] <= mem_dq_o;
      else begin
        dev_col  <= mem_addr_o[COL_W-1:0];
        dev_left <= 4;
      end
    end else if (dev_left > 0) begin
      dev_col  <= dev_col + 1'b1;
      dev_left <= dev_left - 1;
    end
  end
  assign mem_dq_i = (dev_left > 0) ? dev_mem[{dev_row, dev_col}] : '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    check(busy_o == 1'b0, {req, " busy"}, 32'(busy_o), 0);
    check({mem_cs_no, mem_ras_no, mem_cas_no, mem_we_no} == 4'hF, {req, " pins"},
          32'({mem_cs_no, mem_ras_no, mem_cas_no, mem_we_no}), 32'hF);
    check(rvalid_o == 1'b0, {req, " rvalid"}, 32'(rvalid_o), 0);
  endtask

  task automatic do_txn(input bit we, input logic [7:0] a, input logic [15:0] d, input bit poke);
    logic [2:0] c;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    // R2 row phase
    check(!mem_ras_no && !mem_cs_no && mem_cas_no, "R2 row strobe",
          32'({mem_cs_no, mem_ras_no, mem_cas_no}), 32'b001);
    check(mem_addr_o == a[7:3], "R2 row addr", 32'(mem_addr_o), 32'(a[7:3]));
    check(busy_o, "R9 busy after accept", 32'(busy_o), 1);
    for (int k = 1; k < ACT; k++) begin
      @(negedge clk_i);
      req_i = 1'b0;
      if (poke && k == 1) begin
        req_i = 1'b1; we_i = ~we; addr_i = ~a; wdata_i = ~d;
      end
      check(mem_ras_no && mem_cas_no && !mem_cs_no, "R3 activation wait",
            32'({mem_cs_no, mem_ras_no, mem_cas_no}), 32'b011);
    end
    @(negedge clk_i);
    req_i = 1'b0;
    check(!mem_cas_no && mem_ras_no && !mem_cs_no, "R3 column strobe timing",
          32'({mem_cs_no, mem_ras_no, mem_cas_no}), 32'b010);
    check(mem_addr_o == {2'b00, a[2:0]}, "R4 column addr", 32'(mem_addr_o), 32'(a[2:0]));
    check(mem_we_no == !we, "R4 write enable", 32'(mem_we_no), 32'(!we));
    if (we) begin
      check(mem_dq_o == d, "R8 write data", 32'(mem_dq_o), 32'(d));
      exp_mem[a] = d;
    end else begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        c = a[2:0] + 3'(k);
        check(rvalid_o, "R5 read valid", 32'(rvalid_o), 1);
        check(mem_addr_o == {2'b00, c}, "R7 burst column wrap", 32'(mem_addr_o), 32'(c));
        check(rdata_o == exp_mem[{a[7:3], c}], "R6 burst word",
              32'(rdata_o), 32'(exp_mem[{a[7:3], c}]));
      end
    end
    @(negedge clk_i);
    check(!busy_o, "R9 busy end", 32'(busy_o), 0);
    check(!rvalid_o, "R8 no extra word", 32'(rvalid_o), 0);
    if (poke) check(mem_ras_no && mem_cs_no, "R10 request ignored",
                    32'({mem_cs_no, mem_ras_no}), 32'b11);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = 16'(i * 37 + 5);
      exp_mem[i] = 16'(i * 37 + 5);
    end
    #1;
    chk_idle("R1 during reset");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 after reset");

    for (int v = 0; v < NV; v++)
      do_txn(VEC[v][24], VEC[v][23:16], VEC[v][15:0], 1'b0);

    // request while busy is ignored
    do_txn(1'b0, 8'h6A, 16'h0000, 1'b1);
    do_txn(1'b1, 8'h33, 16'h7777, 1'b1);
    do_txn(1'b0, 8'h31, 16'h0000, 1'b0);

    // reset in the middle of an access
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 8'h44;
    @(negedge clk_i);
    req_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk_idle("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_txn(1'b0, 8'h46, 16'h0000, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule